// File: doc/BRIEF.md
# Two-Sample Pair Sequence Detector

This block watches two single-bit lines, `a_i` and `b_i`, sampled on every rising clock edge. It reports a hit when the pair (a,b) = (1,0) in one sample is followed directly by (a,b) = (0,1) in the very next sample. Any other value in between breaks the match. Only these two adjacent samples count. No longer pattern is tracked.

The parameter `MEALY` selects how the hit output is timed. With `MEALY = 0` (Moore timing), the output is decoded from the registered state alone. It changes only at a clock edge, and it is high during the cycle that follows the edge which sampled (0,1). With `MEALY = 1` (Mealy timing), only the fact "the last sample was (1,0)" is stored. That stored flag is combined with the live inputs, so the output rises as soon as (0,1) appears on the inputs. This is one cycle earlier than Moore timing, and the output also follows any change of the inputs within the cycle.

The state machine has three states. `PS_IDLE` means no useful history. `PS_ARMED` means the last sample was (1,0). `PS_MATCH` means the last two samples formed the pattern, and it is used by Moore timing only. The transitions are:
- From any state, a (1,0) sample goes to `PS_ARMED`.
- From `PS_ARMED`, a (0,1) sample goes to `PS_MATCH` with Moore timing, or to `PS_IDLE` with Mealy timing.
- Every other sample goes to `PS_IDLE`.

Top module: `pairseq_detect`

## Requirements
- R1: While `rst_n` is low the state is `PS_IDLE` and `hit_o` is 0. A sample taken while `rst_n` is low counts as no history, so a (0,1) sample in the first cycle after release gives no hit.
- R2: With `MEALY = 1`, `hit_o` is 1 in the cycle when the last sampled pair was (a,b)=(1,0) and the live inputs are (a,b)=(0,1). In every other case it is 0.
- R3: With `MEALY = 1`, `hit_o` follows the live inputs within a cycle. Moving the inputs away from (0,1) before the next edge drops `hit_o` at once.
- R4: With `MEALY = 0`, `hit_o` is 1 in the cycle after the edge that sampled (0,1), when the edge before that sampled (1,0). This is one cycle later than Mealy timing.
- R5: With `MEALY = 0`, `hit_o` depends only on the registered state. It is high for exactly one cycle per match, and changes to the inputs within a cycle do not affect it.
- R6: No hit occurs if the two samples are not adjacent or differ from the pattern. This includes (1,0),(0,0),(0,1) and (1,1),(0,1), and (0,1) followed by (1,0).
- R7: A (1,0) sample re-arms from any state. Consecutive patterns such as (1,0),(0,1),(1,0),(0,1) each produce their own hit, and (1,0),(1,0),(0,1) produces one hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 1 | First observed line |
| b_i | input | 1 | Second observed line |
| hit_o | output | 1 | Pattern detected (timing set by `MEALY`) |

## Verification
On every cycle, the assertions check the following, each in both directions:
- With Mealy timing, the output equals the previous sample combined with the live inputs.
- With Moore timing, the output equals the two previous samples.
- The Moore pulse never lasts two cycles.
- The output is low while reset is held.

Some behaviour only the bench scenarios can show. These are the output moving within a cycle when the inputs change between edges, the one-cycle offset between the two variants running side by side, and the fact that history sampled during reset is discarded.

// File: rtl/pairseq_pkg.sv
package pairseq_pkg;
    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_ARMED = 2'd1,
        PS_MATCH = 2'd2
    } pairseq_state_e;

    localparam int PAIR_W = 2;
    localparam logic [PAIR_W-1:0] PAIR_FIRST  = 2'b10; // {a,b}
    localparam logic [PAIR_W-1:0] PAIR_SECOND = 2'b01;
endpackage

// File: rtl/pairseq_fsm.sv
module pairseq_fsm
    import pairseq_pkg::*;
#(
    parameter bit MEALY = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PAIR_W-1:0]   pair_i,
    output pairseq_state_e      state_o
);
    pairseq_state_e state_q, state_d;
    logic is_first, is_second;

    assign is_first  = (pair_i == PAIR_FIRST);
    assign is_second = (pair_i == PAIR_SECOND);

    always_comb begin
        state_d = PS_IDLE;
        unique case (state_q)
            PS_IDLE:  state_d = is_first ? PS_ARMED : PS_IDLE;
            PS_ARMED: begin
                if (is_first)
                    state_d = PS_ARMED;
                else if (is_second && !MEALY)
                    state_d = PS_MATCH;
                else
                    state_d = PS_IDLE;
            end
            PS_MATCH: state_d = is_first ? PS_ARMED : PS_IDLE;
            default:  state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PS_IDLE;
        else
            state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/pairseq_out.sv
module pairseq_out
    import pairseq_pkg::*;
#(
    parameter bit MEALY = 1'b0
) (
    input  pairseq_state_e    state_i,
    input  logic [PAIR_W-1:0] pair_i,
    output logic              hit_o
);
    generate
        if (MEALY) begin : g_mealy
            always_comb begin
                hit_o = 1'b0;
                unique case (state_i)
                    PS_ARMED: hit_o = (pair_i == PAIR_SECOND);
                    default:  hit_o = 1'b0;
                endcase
            end
        end else begin : g_moore
            always_comb begin
                hit_o = 1'b0;
                unique case (state_i)
                    PS_MATCH: hit_o = 1'b1;
                    default:  hit_o = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/pairseq_detect.sv
module pairseq_detect
    import pairseq_pkg::*;
#(
    parameter bit MEALY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    output logic hit_o
);
    logic [PAIR_W-1:0] pair;
    pairseq_state_e    state;

    assign pair = {a_i, b_i};

    pairseq_fsm #(.MEALY(MEALY)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pair_i  (pair),
        .state_o (state)
    );

    pairseq_out #(.MEALY(MEALY)) u_out (
        .state_i (state),
        .pair_i  (pair),
        .hit_o   (hit_o)
    );
endmodule

// File: rtl/pairseq_checker.sv
module pairseq_checker #(
    parameter bit MEALY = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic a_i,
    input logic b_i,
    input logic hit_o
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!hit_o)
                else $error("hit during reset");
        end
    end

    generate
        if (MEALY) begin : g_mealy_chk
            p_mealy_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
                hit_o |-> (!a_i && b_i && $past(a_i && !b_i)));
            p_mealy_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(a_i && !b_i) && !a_i && b_i) |-> hit_o);
        end else begin : g_moore_chk
            p_moore_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
                hit_o |-> ($past(!a_i && b_i) && $past(a_i && !b_i, 2)));
            p_moore_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n, 2) && $past(rst_n) && $past(a_i && !b_i, 2)
                 && $past(!a_i && b_i)) |-> hit_o);
            p_moore_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
                hit_o |=> !hit_o);
        end
    endgenerate
endmodule

bind pairseq_detect pairseq_checker #(.MEALY(MEALY)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (a_i),
    .b_i   (b_i),
    .hit_o (hit_o)
);

// File: tb/pairseq_detect_tb.sv
module pairseq_detect_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a = 1'b0;
    logic b = 1'b0;
    logic hit_moore, hit_mealy;
    int total = 0;
    int bad = 0;
    int hist[$];   // newest first; 4 = no valid history
    logic [7:0] lfsr = 8'hA5;

    always #5 clk = ~clk;

    pairseq_detect #(.MEALY(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .hit_o(hit_moore));
    pairseq_detect #(.MEALY(1'b1)) u_dut_mealy (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .hit_o(hit_mealy));

    always @(posedge clk) begin
        hist.push_front(rst_n ? int'({a, b}) : 4);
        if (hist.size() > 4) void'(hist.pop_back());
    end

    function automatic int h(int i);
        return (hist.size() > i) ? hist[i] : 4;
    endfunction

    task automatic compare(string tag);
        logic exp_moore, exp_mealy;
        exp_moore = rst_n && (h(1) == 2) && (h(0) == 1);
        exp_mealy = rst_n && (h(0) == 2) && ({a, b} == 2'b01);
        total += 2;
        if (hit_moore !== exp_moore) begin
            bad++;
            $display("FAIL %s moore: actual=%b expected=%b", tag, hit_moore, exp_moore);
        end
        if (hit_mealy !== exp_mealy) begin
            bad++;
            $display("FAIL %s mealy: actual=%b expected=%b", tag, hit_mealy, exp_mealy);
        end
    endtask

    task automatic step(logic [1:0] ab, string tag);
        @(negedge clk);
        {a, b} = ab;
        #2;
        compare(tag);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset holds output low; history sampled in reset is discarded
        step(2'b10, "R1");
        step(2'b10, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        {a, b} = 2'b01;
        #2;
        compare("R1");
        step(2'b01, "R1");
        step(2'b00, "R1");

        // R2 / R4: basic match, both timings
        step(2'b10, "R2");
        step(2'b01, "R2");
        step(2'b00, "R4");
        step(2'b00, "R5");

        // R3: live inputs move within a cycle
        step(2'b10, "R3");
        step(2'b01, "R3");
        {a, b} = 2'b00;
        #1;
        compare("R3");
        {a, b} = 2'b01;
        #1;
        compare("R3");
        step(2'b11, "R5");
        {a, b} = 2'b00;
        #1;
        compare("R5");
        step(2'b00, "R5");

        // R6: non-adjacent or wrong patterns
        step(2'b10, "R6");
        step(2'b00, "R6");
        step(2'b01, "R6");
        step(2'b11, "R6");
        step(2'b01, "R6");
        step(2'b01, "R6");
        step(2'b10, "R6");
        step(2'b11, "R6");
        step(2'b00, "R6");

        // R7: re-arm and back-to-back matches
        step(2'b10, "R7");
        step(2'b01, "R7");
        step(2'b10, "R7");
        step(2'b01, "R7");
        step(2'b10, "R7");
        step(2'b10, "R7");
        step(2'b01, "R7");
        step(2'b00, "R7");
        step(2'b00, "R7");

        // R6 / R7: pseudo-random sweep
        for (int i = 0; i < 120; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[1:0], "R6");
        end

        // R1: mid-run reset clears history
        step(2'b10, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        {a, b} = 2'b01;
        #2;
        compare("R1");
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        compare("R1");
        step(2'b00, "R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule